// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block follows the command-level state of every bank in a parameterized SDR/DDR SDRAM device. A memory controller passes each command it intends to issue through the tracker, which accepts only one command per cycle. The block keeps a state for each bank (idle after reset, precharged, or active), the row that each active bank holds open, and the countdown windows that follow each command. A command that breaks a rule is refused: the block leaves all bank state untouched and raises a one-cycle flag.

Before issuing, the controller reads the per-bank "legal now" flags for activate, column access and precharge, plus one flag for auto refresh. An accepted column read produces a read-valid pulse, tagged with its bank and column, exactly CAS latency cycles later. Bank count, row and column address widths, and the activate-to-column, precharge-to-activate, CAS latency and refresh durations are all parameters.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After synchronous reset every bank is idle, every open row reads 0, `rd_valid`, `cmd_illegal` and `refresh_busy` are 0, `ref_ok` is 1, every `pre_ok` bit is 1 and every `act_ok` and `col_ok` bit is 0.
- R2: Bank b reports its state in `bank_state[2b+1:2b]` (0 idle, 1 precharged, 2 active) and its open row in `open_row[b*ROW_W +: ROW_W]`.
- R3: A precharge (`cmd_op`=4) is accepted for any bank in any state when no refresh is running. It moves that bank to precharged, and an activate to that bank becomes legal T_RP cycles after the precharge cycle.
- R4: An activate (`cmd_op`=1) is accepted only for a precharged bank whose precharge window has expired. It makes the bank active and records `cmd_row` as its open row. An activate to an idle or active bank is refused.
- R5: A column read (`cmd_op`=2) or write (`cmd_op`=3) is accepted only for an active bank, starting T_RCD cycles after its activate. Any number of column commands may follow with no further activate, and they leave the bank state and open row unchanged.
- R6: An accepted read drives `rd_valid` high for one cycle exactly T_CL cycles later, with that read's bank on `rd_bank` and column on `rd_col`. Writes and refused reads never produce `rd_valid`.
- R7: A refused command, including the reserved op codes 6 and 7 and a bank index at or above the bank count, sets `cmd_illegal` in the following cycle and changes no bank state, open row or read output. No-op (`cmd_op`=0) is never refused.
- R8: Auto refresh (`cmd_op`=5) is accepted only when no bank is active, no precharge window is running and no refresh is running. It moves every bank to precharged. `refresh_busy` then stays high for T_RFC-1 cycles, during which every command except no-op is refused.
- R9: `act_ok`, `col_ok` and `pre_ok` (one bit per bank) and `ref_ok` are high in exactly the cycles in which that command would be accepted.
- R10: Each bank times its own windows, so commands to different banks may overlap, and a command to one bank never changes another bank's state, row or windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row address for activate |
| cmd_col | input | COL_W | Column address for read/write |
| bank_state | output | 2*NB | Packed per-bank state |
| open_row | output | NB*ROW_W | Packed per-bank open row |
| act_ok | output | NB | Activate legal now, per bank |
| col_ok | output | NB | Read/write legal now, per bank |
| pre_ok | output | NB | Precharge legal now, per bank |
| ref_ok | output | 1 | Auto refresh legal now |
| refresh_busy | output | 1 | Refresh window running |
| cmd_illegal | output | 1 | Previous cycle's command was refused |
| rd_valid | output | 1 | Read data due this cycle |
| rd_bank | output | BANK_W | Bank of the due read |
| rd_col | output | COL_W | Column of the due read |

## Verification
A bank whose stored state is wrong shows up at the ports in the very next cycle. It appears as a changed `bank_state` or `open_row` field, or as a legal-now flag whose value disagrees with the command rules. A window counter that starts from the wrong value or counts at the wrong rate moves the rise of `act_ok`, `col_ok` or `ref_ok` off its expected cycle by at least one. A fault in the read pipeline moves or drops the `rd_valid` pulse, or corrupts its bank or column tag, on the exact T_CL cycle. Because a behavioural model is compared against every output in every cycle, each of these shows up at the first cycle in which it differs.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_PRECH  = 2'd1,
        BK_ACTIVE = 2'd2
    } bank_st_e;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REFR = 3'd5
    } cmd_op_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic refr;
    } accept_t;

    // bits needed to hold a countdown that starts at n-1
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sbt_bank.sv
module sbt_bank
    import sbt_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_go,
    input  logic             col_go,
    input  logic             pre_go,
    input  logic             ref_go,
    input  logic             lock,
    input  logic [ROW_W-1:0] row_in,
    output bank_st_e         st,
    output logic [ROW_W-1:0] row_q,
    output logic             act_ok,
    output logic             col_ok,
    output logic             pre_ok,
    output logic             quiet
);

    localparam int RCD_W = cnt_width(T_RCD);
    localparam int RP_W  = cnt_width(T_RP);
    localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(T_RCD - 1);
    localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(T_RP - 1);

    logic [RCD_W-1:0] rcd_q;
    logic [RP_W-1:0]  rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= BK_IDLE;
            row_q <= '0;
            rcd_q <= '0;
            rp_q  <= '0;
        end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (rp_q != '0)  rp_q  <= rp_q - 1'b1;
            if (act_go) begin
                st    <= BK_ACTIVE;
                row_q <= row_in;
                rcd_q <= RCD_LOAD;
            end
            if (pre_go) begin
                st   <= BK_PRECH;
                rp_q <= RP_LOAD;
            end
            if (ref_go) st <= BK_PRECH;
        end
    end

    always_comb begin
        act_ok = !lock && (st == BK_PRECH) && (rp_q == '0);
        col_ok = !lock && (st == BK_ACTIVE) && (rcd_q == '0);
        pre_ok = !lock;
        quiet  = (st != BK_ACTIVE) && (rp_q == '0);
    end

    AST_COL_ON_OPEN_BANK: assert property (@(posedge clk) disable iff (rst)
        col_go |-> (st == BK_ACTIVE) && (rcd_q == '0)); // R5
    AST_ACT_ON_PRECH_BANK: assert property (@(posedge clk) disable iff (rst)
        act_go |-> (st == BK_PRECH) && (rp_q == '0)); // R4
    AST_ACT_LATCHES_ROW: assert property (@(posedge clk) disable iff (rst)
        act_go |=> (st == BK_ACTIVE) && (row_q == $past(row_in))); // R4
    AST_PRE_REACHES_PRECH: assert property (@(posedge clk) disable iff (rst)
        pre_go |=> (st == BK_PRECH)); // R3
    AST_COL_KEEPS_ROW: assert property (@(posedge clk) disable iff (rst)
        col_go |=> $stable(row_q) && (st == BK_ACTIVE)); // R5

endmodule

// File: rtl/sbt_refresh.sv
module sbt_refresh #(
    parameter int T_RFC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int RFC_W = sbt_pkg::cnt_width(T_RFC);
    localparam logic [RFC_W-1:0] RFC_LOAD = RFC_W'(T_RFC - 1);

    logic [RFC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (start)     cnt_q <= RFC_LOAD;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_REF_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R8

endmodule

// File: rtl/sbt_read_pipe.sv
module sbt_read_pipe #(
    parameter int DEPTH  = 3,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output logic              out_vld,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);

    logic              vld_q  [DEPTH];
    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [COL_W-1:0]  col_q  [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i]  <= 1'b0;
                bank_q[i] <= '0;
                col_q[i]  <= '0;
            end
        end else begin
            vld_q[0]  <= push;
            bank_q[0] <= in_bank;
            col_q[0]  <= in_col;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i]  <= vld_q[i-1];
                bank_q[i] <= bank_q[i-1];
                col_q[i]  <= col_q[i-1];
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_bank = bank_q[DEPTH-1];
    assign out_col  = col_q[DEPTH-1];

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NB     = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_CL   = 3,
    parameter int T_RFC  = 8,
    parameter int BANK_W = (NB < 2) ? 1 : $clog2(NB)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cmd_op,
    input  logic [BANK_W-1:0]   cmd_bank,
    input  logic [ROW_W-1:0]    cmd_row,
    input  logic [COL_W-1:0]    cmd_col,
    output logic [2*NB-1:0]     bank_state,
    output logic [NB*ROW_W-1:0] open_row,
    output logic [NB-1:0]       act_ok,
    output logic [NB-1:0]       col_ok,
    output logic [NB-1:0]       pre_ok,
    output logic                ref_ok,
    output logic                refresh_busy,
    output logic                cmd_illegal,
    output logic                rd_valid,
    output logic [BANK_W-1:0]   rd_bank,
    output logic [COL_W-1:0]    rd_col
);

    bank_st_e      st_w  [NB];
    logic [NB-1:0] quiet_w;
    logic          bank_in_range;
    logic          legal_now;
    accept_t       acc;

    // ---------------- command decode and acceptance ----------------
    always_comb begin
        bank_in_range = (32'(cmd_bank) < NB);
        legal_now     = 1'b0;
        case (cmd_op)
            OP_NOP:        legal_now = 1'b1;
            OP_ACT:        legal_now = bank_in_range && act_ok[cmd_bank];
            OP_RD, OP_WR:  legal_now = bank_in_range && col_ok[cmd_bank];
            OP_PRE:        legal_now = bank_in_range && pre_ok[cmd_bank];
            OP_REFR:       legal_now = ref_ok;
            default:       legal_now = 1'b0;
        endcase
        acc.act  = legal_now && (cmd_op == OP_ACT);
        acc.rd   = legal_now && (cmd_op == OP_RD);
        acc.wr   = legal_now && (cmd_op == OP_WR);
        acc.pre  = legal_now && (cmd_op == OP_PRE);
        acc.refr = legal_now && (cmd_op == OP_REFR);
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_illegal <= 1'b0;
        else     cmd_illegal <= !legal_now;
    end

    // ---------------- per-bank trackers ----------------
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank == BANK_W'(b));
        sbt_bank #(
            .ROW_W (ROW_W),
            .T_RCD (T_RCD),
            .T_RP  (T_RP)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .act_go (acc.act && hit),
            .col_go ((acc.rd || acc.wr) && hit),
            .pre_go (acc.pre && hit),
            .ref_go (acc.refr),
            .lock   (refresh_busy),
            .row_in (cmd_row),
            .st     (st_w[b]),
            .row_q  (open_row[b*ROW_W +: ROW_W]),
            .act_ok (act_ok[b]),
            .col_ok (col_ok[b]),
            .pre_ok (pre_ok[b]),
            .quiet  (quiet_w[b])
        );
        assign bank_state[2*b +: 2] = st_w[b];
    end

    assign ref_ok = !refresh_busy && (&quiet_w);

    // ---------------- refresh window ----------------
    sbt_refresh #(.T_RFC(T_RFC)) u_refresh (
        .clk   (clk),
        .rst   (rst),
        .start (acc.refr),
        .busy  (refresh_busy)
    );

    // ---------------- read latency pipe ----------------
    sbt_read_pipe #(
        .DEPTH  (T_CL),
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_rd_pipe (
        .clk      (clk),
        .rst      (rst),
        .push     (acc.rd),
        .in_bank  (cmd_bank),
        .in_col   (cmd_col),
        .out_vld  (rd_valid),
        .out_bank (rd_bank),
        .out_col  (rd_col)
    );

    // ---------------- checks on the assembled state ----------------
    logic any_active, all_prech;
    always_comb begin
        any_active = 1'b0;
        all_prech  = 1'b1;
        for (int b = 0; b < NB; b++) begin
            if (bank_state[2*b +: 2] == 2'd2) any_active = 1'b1;
            if (bank_state[2*b +: 2] != 2'd1) all_prech  = 1'b0;
        end
    end

    AST_REFUSED_FREEZES: assert property (@(posedge clk) disable iff (rst)
        !legal_now |=> $stable(bank_state) && $stable(open_row)); // R7
    AST_REF_WITH_NO_OPEN_ROW: assert property (@(posedge clk) disable iff (rst)
        acc.refr |-> !any_active); // R8
    AST_BUSY_MEANS_PRECH: assert property (@(posedge clk) disable iff (rst)
        refresh_busy |-> all_prech); // R8
    AST_OK_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (act_ok & col_ok) == '0); // R9

endmodule

// File: tb/sdram_bank_tracker_tb.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb;

    localparam int NB     = 4;
    localparam int ROW_W  = 6;
    localparam int COL_W  = 5;
    localparam int T_RCD  = 3;
    localparam int T_RP   = 2;
    localparam int T_CL   = 4;
    localparam int T_RFC  = 6;
    localparam int BANK_W = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [2:0]          cmd_op = '0;
    logic [BANK_W-1:0]   cmd_bank = '0;
    logic [ROW_W-1:0]    cmd_row = '0;
    logic [COL_W-1:0]    cmd_col = '0;
    logic [2*NB-1:0]     bank_state;
    logic [NB*ROW_W-1:0] open_row;
    logic [NB-1:0]       act_ok, col_ok, pre_ok;
    logic                ref_ok, refresh_busy, cmd_illegal, rd_valid;
    logic [BANK_W-1:0]   rd_bank;
    logic [COL_W-1:0]    rd_col;

    always #4 clk = ~clk;

    sdram_bank_tracker #(
        .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_CL(T_CL), .T_RFC(T_RFC), .BANK_W(BANK_W)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .bank_state(bank_state),
        .open_row(open_row), .act_ok(act_ok), .col_ok(col_ok),
        .pre_ok(pre_ok), .ref_ok(ref_ok), .refresh_busy(refresh_busy),
        .cmd_illegal(cmd_illegal), .rd_valid(rd_valid), .rd_bank(rd_bank),
        .rd_col(rd_col)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase = "R1";

    // behavioural reference state for the current cycle
    int m_st [NB];
    int m_row[NB];
    int m_rcd[NB];
    int m_rp [NB];
    int m_rfc;
    bit m_ill;
    int q_due[$];
    int q_bank[$];
    int q_col[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", phase, tag, cyc, act, exp);
        end
    endtask

    function automatic bit m_busy();
        return m_rfc != 0;
    endfunction

    function automatic bit m_act_ok(input int b);
        return !m_busy() && m_st[b] == 1 && m_rp[b] == 0;
    endfunction

    function automatic bit m_col_ok(input int b);
        return !m_busy() && m_st[b] == 2 && m_rcd[b] == 0;
    endfunction

    function automatic bit m_ref_ok();
        bit ok = !m_busy();
        for (int b = 0; b < NB; b++)
            if (m_st[b] == 2 || m_rp[b] != 0) ok = 0;
        return ok;
    endfunction

    function automatic bit m_legal(input int op, input int b);
        case (op)
            0: return 1;
            1: return m_act_ok(b);
            2, 3: return m_col_ok(b);
            4: return !m_busy();
            5: return m_ref_ok();
            default: return 0;
        endcase
    endfunction

    task automatic compare_all();
        bit exp_rv = 0;
        for (int b = 0; b < NB; b++) begin
            chk("R2 state", int'(bank_state[2*b +: 2]), m_st[b]);
            chk("R2 row", int'(open_row[b*ROW_W +: ROW_W]), m_row[b]);
            chk("R9 act_ok", int'(act_ok[b]), int'(m_act_ok(b)));
            chk("R9 col_ok", int'(col_ok[b]), int'(m_col_ok(b)));
            chk("R9 pre_ok", int'(pre_ok[b]), int'(!m_busy()));
        end
        chk("R9 ref_ok", int'(ref_ok), int'(m_ref_ok()));
        chk("R8 refresh_busy", int'(refresh_busy), int'(m_busy()));
        chk("R7 cmd_illegal", int'(cmd_illegal), int'(m_ill));
        if (q_due.size() > 0 && q_due[0] == cyc) exp_rv = 1;
        chk("R6 rd_valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv) begin
            chk("R6 rd_bank", int'(rd_bank), q_bank[0]);
            chk("R6 rd_col", int'(rd_col), q_col[0]);
            void'(q_due.pop_front());
            void'(q_bank.pop_front());
            void'(q_col.pop_front());
        end
    endtask

    // one clock cycle: compare, drive, advance the model
    task automatic step(input int op, input int b, input int row, input int col);
        bit lg;
        @(negedge clk);
        compare_all();
        cmd_op   = 3'(op);
        cmd_bank = BANK_W'(b);
        cmd_row  = ROW_W'(row);
        cmd_col  = COL_W'(col);
        lg = m_legal(op, b);
        m_ill = !lg;
        for (int k = 0; k < NB; k++) begin
            if (m_rcd[k] > 0) m_rcd[k]--;
            if (m_rp[k] > 0)  m_rp[k]--;
        end
        if (m_rfc > 0) m_rfc--;
        if (lg) begin
            case (op)
                1: begin m_st[b] = 2; m_row[b] = row; m_rcd[b] = T_RCD - 1; end
                2: begin q_due.push_back(cyc + T_CL); q_bank.push_back(b); q_col.push_back(col); end
                4: begin m_st[b] = 1; m_rp[b] = T_RP - 1; end
                5: begin
                    for (int k = 0; k < NB; k++) m_st[k] = 1;
                    m_rfc = T_RFC - 1;
                end
                default: ;
            endcase
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    bit done = 0;

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_st[b] = 0; m_row[b] = 0; m_rcd[b] = 0; m_rp[b] = 0;
        end
        m_rfc = 0;
        m_ill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        phase = "R1";                        // reset values
        idle(2);

        phase = "R4";                        // activate from idle is refused
        step(1, 0, 5, 0);
        idle(1);

        phase = "R3";                        // precharge, early activate refused, then on time
        step(4, 0, 0, 0);
        step(1, 0, 9, 0);
        idle(T_RP - 2);
        step(1, 0, 9, 0);
        step(1, 0, 3, 0);                    // R4: activate to active bank refused

        phase = "R5";                        // column before tRCD refused, then several columns
        step(2, 0, 0, 1);
        idle(T_RCD - 2);
        step(2, 0, 0, 7);
        step(3, 0, 0, 8);
        step(2, 0, 0, 9);

        phase = "R6";                        // back-to-back reads
        step(2, 0, 0, 10);
        step(2, 0, 0, 11);
        idle(T_CL + 1);

        phase = "R10";                       // overlapping windows on other banks
        step(4, 1, 0, 0);
        step(4, 2, 0, 0);
        step(1, 1, 21, 0);
        step(1, 2, 42, 0);
        step(2, 1, 0, 3);
        step(2, 1, 0, 4);
        step(2, 2, 0, 5);
        step(4, 0, 0, 0);
        idle(T_CL + 2);

        phase = "R8";                        // refresh needs all banks quiet
        step(5, 0, 0, 0);
        step(4, 1, 0, 0);
        step(4, 2, 0, 0);
        step(5, 0, 0, 0);
        idle(T_RP);
        step(5, 0, 0, 0);
        step(4, 3, 0, 0);
        step(1, 0, 1, 0);
        idle(T_RFC);
        step(1, 3, 17, 0);

        phase = "R7";                        // reserved op codes
        step(6, 1, 0, 0);
        step(7, 2, 0, 0);
        idle(T_RCD + 1);

        phase = "R9";                        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 15);
            int op;
            if (r < 4)       op = 1;
            else if (r < 8)  op = 2;
            else if (r < 10) op = 3;
            else if (r < 13) op = 4;
            else if (r < 14) op = 5;
            else if (r < 15) op = 0;
            else             op = 6;
            step(op, $urandom_range(0, NB - 1), $urandom_range(0, 63), $urandom_range(0, 31));
        end
        idle(T_CL + 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule